// File: doc/BRIEF.md
# Crank-Wheel Sine Pattern Generator

This block produces a stream of signed sine samples that imitates the signal of a toothed crank-position sensor. One revolution of the pattern holds 180 sine cycles of 50 samples each, 9000 positions in all. Two cycles are blanked to act as reference gaps. The pattern is built inside the block from a computed single-cycle sine table and gap logic, so it needs no external memory contents.

The block emits one sample each time a programmable tick interval elapses. Software may rewrite the interval length at any time, typically every few milliseconds, to follow engine speed. A rewrite restarts the interval being counted, so the sample on the output is held for the whole new interval before the pattern moves on. The block also raises a one-clock strobe with each new sample, and a one-clock marker when the pattern begins again at position 0.

Top module: `crank_sine_gen`

## Requirements
- R1: While `rst` is high, and in every clock after a clock in which `enable` was low, `sampleOut` is 0, `sampleValid` and `patternStart` are low, and the pattern position is reset to 0.
- R2: On an advance to position a that is outside the gaps, `sampleOut` equals round(32767 * sin(2*pi*(a mod 50)/50)) as a 16-bit two's complement value. Position 0 gives 0 and position 1 gives 4107.
- R3: With a steady period P of 2 or more, a new sample appears exactly once every P clocks. `sampleOut` holds its value in the clocks between samples.
- R4: After position 8999 the next advance goes to position 0. `patternStart` is high for one clock, in the same clock as the `sampleValid` of that advance.
- R5: Positions 4425 to 4499 and 8925 to 8999 output 0. These are the negative half of the 89th and 179th cycles and all of the 90th and 180th cycles.
- R6: With a steady period of 0 or 1, the pattern advances by one position on every clock.
- R7: When `periodIn` differs from the value sampled on the previous clock, the interval restarts at that clock and no advance happens in it. The next advance comes P_new clocks later.
- R8: `sampleValid` is high for exactly one clock per advance, and `patternStart` is never high without `sampleValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the generator; low clears position and output |
| periodIn | input | 16 | Interval length in clocks per sample (0 and 1 both mean every clock) |
| sampleOut | output | 16 | Current signed sample |
| sampleValid | output | 1 | One-clock strobe on each new sample |
| patternStart | output | 1 | One-clock marker when the pattern returns to position 0 |

## Verification
Several rules are checked on every clock by embedded properties:
- clearing while disabled, and the output holding between advances;
- the interval timer staying within the held period;
- no advance in a clock where the period was rewritten;
- one advance per clock at fast rates;
- a fully blanked gap cycle;
- the restart marker appearing only at position 0 together with the strobe.

The exact sine values and the exact interval lengths are shown only by the bench, which compares every clock against a reference model. That comparison covers whole passes that reach both gaps and the wrap, and runs in which the period, enable and reset change at random.

// File: rtl/crank_pkg.sv
package crank_pkg;

  // Strobes sent from the tick control to the pattern datapath
  typedef struct packed {
    logic clear;    // hold position at 0 and output at zero
    logic advance;  // step to the next pattern position this clock
  } crank_ctrl_t;

endpackage

// File: rtl/crank_tick_ctrl.sv
module crank_tick_ctrl
  import crank_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] periodIn,
  output crank_ctrl_t         ctrl
);

  logic [PERIOD_W-1:0] timerQ;
  logic [PERIOD_W-1:0] periodHeld;
  logic [PERIOD_W-1:0] lastTick;
  logic                idle;
  logic                reload;
  logic                expire;

  always_comb begin
    idle         = rst || !enable;
    reload       = !idle && (periodIn != periodHeld);
    lastTick     = (periodHeld <= PERIOD_W'(1)) ? '0 : periodHeld - 1'b1;
    expire       = (timerQ >= lastTick);
    ctrl.clear   = idle;
    ctrl.advance = !idle && !reload && expire;
  end

  always_ff @(posedge clk) begin
    if (idle || reload) begin
      timerQ     <= '0;
      periodHeld <= periodIn;
    end else if (expire) begin
      timerQ <= '0;
    end else begin
      timerQ <= timerQ + 1'b1;
    end
  end

  // R3
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !reload) |-> (timerQ <= lastTick));

  // R7
  reload_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && periodIn != periodHeld) |=> (timerQ == '0));

endmodule

// File: rtl/crank_pattern_path.sv
module crank_pattern_path
  import crank_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int CYCLE_LEN  = 50,
  parameter int NUM_CYCLES = 180,
  parameter int GAP_A      = 89,
  parameter int GAP_B      = 179
) (
  input  logic                       clk,
  input  logic                       rst,
  input  crank_ctrl_t                ctrl,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       sampleValid,
  output logic                       patternStart
);

  localparam int  PH_W = $clog2(CYCLE_LEN);
  localparam int  CY_W = $clog2(NUM_CYCLES);
  localparam int  HALF = CYCLE_LEN / 2;
  localparam real AMPL = (2.0 ** (SAMPLE_W - 1)) - 1.0;
  localparam real TWO_PI = 6.283185307179586;
  // 0-based cycle whose negative half starts each gap
  localparam int  GAP_CYC [2] = '{GAP_A - 1, GAP_B - 1};

  logic signed [SAMPLE_W-1:0] sineTbl [CYCLE_LEN];

  for (genvar k = 0; k < CYCLE_LEN; k++) begin : g_sine
    localparam real ANG = TWO_PI * k / CYCLE_LEN;
    assign sineTbl[k] = SAMPLE_W'(int'(AMPL * $sin(ANG)));
  end

  logic [PH_W-1:0] phaseQ, nextPhase;
  logic [CY_W-1:0] cycleQ, nextCycle;
  logic            endPhase, endCycle, wrapNow, blank;
  logic [1:0]      gapHit;

  always_comb begin
    endPhase  = (phaseQ == PH_W'(CYCLE_LEN - 1));
    endCycle  = (cycleQ == CY_W'(NUM_CYCLES - 1));
    nextPhase = endPhase ? '0 : phaseQ + 1'b1;
    nextCycle = endPhase ? (endCycle ? '0 : cycleQ + 1'b1) : cycleQ;
    wrapNow   = endPhase && endCycle;
  end

  for (genvar g = 0; g < 2; g++) begin : g_gap
    assign gapHit[g] = ((nextCycle == CY_W'(GAP_CYC[g])) && (nextPhase >= PH_W'(HALF)))
                    || (nextCycle == CY_W'(GAP_CYC[g] + 1));
  end

  assign blank = |gapHit;

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      phaseQ       <= '0;
      cycleQ       <= '0;
      sampleOut    <= '0;
      sampleValid  <= 1'b0;
      patternStart <= 1'b0;
    end else begin
      sampleValid  <= ctrl.advance;
      patternStart <= ctrl.advance && wrapNow;
      if (ctrl.advance) begin
        phaseQ    <= nextPhase;
        cycleQ    <= nextCycle;
        sampleOut <= blank ? '0 : sineTbl[nextPhase];
      end
    end
  end

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.advance && !ctrl.clear) |=> $stable(sampleOut));

  // R5
  gap_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (cycleQ == CY_W'(GAP_A)) |-> (sampleOut == '0));

  // R4
  start_pos_chk: assert property (@(posedge clk) disable iff (rst)
    patternStart |-> (phaseQ == '0 && cycleQ == '0 && sampleValid));

endmodule

// File: rtl/crank_sine_gen.sv
module crank_sine_gen
  import crank_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int PERIOD_W   = 16,
  parameter int CYCLE_LEN  = 50,
  parameter int NUM_CYCLES = 180,
  parameter int GAP_A      = 89,
  parameter int GAP_B      = 179
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enable,
  input  logic [PERIOD_W-1:0]        periodIn,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       sampleValid,
  output logic                       patternStart
);

  crank_ctrl_t ctrl;

  crank_tick_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .periodIn (periodIn),
    .ctrl     (ctrl)
  );

  crank_pattern_path #(
    .SAMPLE_W   (SAMPLE_W),
    .CYCLE_LEN  (CYCLE_LEN),
    .NUM_CYCLES (NUM_CYCLES),
    .GAP_A      (GAP_A),
    .GAP_B      (GAP_B)
  ) u_path (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .sampleOut    (sampleOut),
    .sampleValid  (sampleValid),
    .patternStart (patternStart)
  );

  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (sampleOut == '0 && !sampleValid && !patternStart));

  // R6
  fast_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && periodIn <= PERIOD_W'(1) && periodIn == $past(periodIn)) |=> sampleValid);

  // R7
  reload_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && periodIn != $past(periodIn)) |=> !sampleValid);

  // R8
  start_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    patternStart |-> sampleValid);

endmodule

// File: tb/crank_sine_gen_tb.sv
module crank_sine_gen_tb;

  localparam int LAST_POS = 8999;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] periodIn = 16'd4;
  logic signed [15:0] sampleOut;
  logic        sampleValid;
  logic        patternStart;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit chkOn = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crank_sine_gen u_dut (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .periodIn     (periodIn),
    .sampleOut    (sampleOut),
    .sampleValid  (sampleValid),
    .patternStart (patternStart)
  );

  // Expected sample at a pattern position, from R2 and R5
  function automatic logic signed [15:0] patVal(input int a);
    if ((a >= 4425 && a <= 4499) || (a >= 8925 && a <= 8999)) return 16'sd0;
    return 16'(int'(32767.0 * $sin(6.283185307179586 * (a % 50) / 50.0)));
  endfunction

  function automatic bit inGap(input int a);
    return (a >= 4425 && a <= 4499) || (a >= 8925 && a <= 8999);
  endfunction

  // Reference model built from the requirements
  int mAddr = 0, mTimer = 0, mPer = 0;
  logic signed [15:0] mSample = 0;
  bit mValid = 0, mRestart = 0, mReload = 0, mIdle = 1;

  always @(posedge clk) begin
    int eff;
    mReload <= 1'b0;
    if (rst || !enable) begin
      mIdle <= 1'b1; mAddr <= 0; mTimer <= 0; mPer <= periodIn;
      mSample <= 0; mValid <= 0; mRestart <= 0;
    end else begin
      mIdle <= 1'b0;
      if (int'(periodIn) != mPer) begin
        mPer <= periodIn; mTimer <= 0; mValid <= 0; mRestart <= 0; mReload <= 1'b1;
      end else begin
        eff = (mPer <= 1) ? 1 : mPer;
        if (mTimer + 1 >= eff) begin
          int na;
          na = (mAddr == LAST_POS) ? 0 : mAddr + 1;
          mTimer <= 0; mAddr <= na; mSample <= patVal(na);
          mValid <= 1; mRestart <= (na == 0);
        end else begin
          mTimer <= mTimer + 1; mValid <= 0; mRestart <= 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    string tag;
    if (chkOn && !done) begin
      if (mIdle) tag = "R1";
      else if (mReload) tag = "R7";
      else if (mRestart) tag = "R4";
      else if (mValid && inGap(mAddr)) tag = "R5";
      else if (mValid && mPer <= 1) tag = "R6";
      else if (mValid) tag = "R2";
      else tag = "R3";
      checks++;
      if (sampleOut !== mSample || sampleValid !== mValid || patternStart !== mRestart) begin
        errors++;
        $display("FAIL %s pos=%0d: got sample=%0d valid=%b start=%b, expected sample=%0d valid=%b start=%b",
                 tag, mAddr, sampleOut, sampleValid, patternStart, mSample, mValid, mRestart);
      end
      // R8: marker only with strobe
      checks++;
      if (patternStart && !sampleValid) begin
        errors++;
        $display("FAIL R8: got start=1 valid=0, expected valid=1");
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chkOn = 1'b1;
    // R1: reset state checked while held
    repeat (2) @(negedge clk);
    rst = 1'b0;
    enable = 1'b1;
    periodIn = 16'd1;
    // R6/R4/R5: a full pass at one sample per clock reaches both gaps and the wrap
    repeat (9100) @(negedge clk);
    periodIn = 16'd0;
    repeat (60) @(negedge clk);
    // R3: steady slow rate
    periodIn = 16'd5;
    repeat (40) @(negedge clk);
    // R7: rewrite in mid interval, then back-to-back rewrites
    repeat (2) @(negedge clk);
    periodIn = 16'd3;
    repeat (1) @(negedge clk);
    periodIn = 16'd7;
    repeat (30) @(negedge clk);
    // R1: disable mid run
    enable = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    repeat (20) @(negedge clk);
    // Random mix of rates, enables and resets
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(0, 39) == 0) periodIn = 16'($urandom_range(0, 6));
      if ($urandom_range(0, 699) == 0) enable = ~enable;
      else if (!enable && $urandom_range(0, 3) == 0) enable = 1'b1;
      rst = ($urandom_range(0, 1499) == 0);
      @(negedge clk);
    end
    rst = 1'b0;
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule